// File: doc/BRIEF.md
# Element-Width Overlay Register File

This block holds thirty-two 64-bit integer registers and gives access to them one packed element at a time. An element is 8, 16, 32 or 64 bits wide. Each access names a base register, an element index and an element width, and the block resolves them to one register and one byte lane within it. A read returns the element right-justified and zero-extended. A write changes only the byte lanes of the addressed element, through per-byte enables.

Two addressing modes are supported. In the linear mode, the storage is one contiguous byte array that starts at the base register. A large index runs on into the registers that follow, and the register number wraps modulo the register count. In the vector mode, a 128-bit register is formed from the base register (low half) and the next register (high half). Elements in this mode are numbered from the most-significant end, and the index must stay below the element count of the 128-bit register. An out-of-range index raises an error flag and suppresses the write.

Top module: `ewr_regfile`

## Requirements
- R1: A synchronous reset clears every byte of every register to zero, so any read after reset returns 0.
- R2: `wsel` encodes the element width: 0 selects 8 bits, 1 selects 16, 2 selects 32 and 3 selects 64. `rd_data` carries the element in its least-significant bits and is zero above the element width.
- R3: With `mode`=0, the element occupies byte address base×8 + idx×(width/8) of a flat byte array. Byte address a is lane a mod 8 of register a/8, and element 0 sits in the least-significant bits of the base register. Indexes that do not fit one register continue into higher-numbered registers, and `err` stays 0.
- R4: Register numbers wrap modulo 32. An access that runs past register 31 continues at register 0.
- R5: With `mode`=1, the 128-bit vector register is made of register base (bytes 0 to 7) and register base+1 (bytes 8 to 15). The element count is 16/(width/8), and element idx lives in physical slot count−1−idx, at byte offset slot×(width/8).
- R6: With `mode`=1 and idx ≥ count, `err` is 1, `rd_data` is 0 and a write leaves all storage unchanged. An idx of count−1 is legal.
- R7: A write updates only the bytes of the addressed element. The element value is taken from the low bits of `wr_data`, and higher bits of `wr_data` are ignored.
- R8: A write takes effect at the rising clock edge. Reads are combinational from the stored state, so the written value appears on `rd_data` in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 1 | 0 = linear overlay, 1 = bounded 128-bit vector |
| wsel | input | 2 | Element width code (0=8, 1=16, 2=32, 3=64 bits) |
| base | input | 5 | Base register number |
| idx | input | 8 | Element index |
| wr_en | input | 1 | Write the addressed element at the next rising edge |
| wr_data | input | 64 | Element value to write, in the low bits |
| rd_data | output | 64 | Addressed element, zero-extended |
| err | output | 1 | Vector-mode index out of range |

## Verification
A wrong register or lane selection sends a write to the wrong bytes. The error shows on the next read of either location, one cycle after the write edge. A wrong byte enable corrupts neighbouring elements, so the bench reads whole 64-bit registers after narrow writes and compares them against a byte-array model. A mirrored-slot mistake or a missed range check shows in the same cycle as a wrong `err` or a nonzero `rd_data`. It also shows one cycle later as changed storage on a linear-mode readback.

// File: rtl/ewr_pkg.sv
package ewr_pkg;
  typedef enum logic [1:0] {EW8 = 2'd0, EW16 = 2'd1, EW32 = 2'd2, EW64 = 2'd3} ew_t;

  // bytes per element
  function automatic logic [3:0] elem_bytes(ew_t w);
    return 4'd1 << w;
  endfunction

  // elements held by one 128-bit vector register
  function automatic logic [4:0] vec_count(ew_t w);
    return 5'd16 >> w;
  endfunction

  // byte-enable pattern of an element starting at lane
  function automatic logic [7:0] lane_mask(ew_t w, logic [2:0] lane);
    logic [7:0] m;
    m = 8'((16'd1 << elem_bytes(w)) - 16'd1);
    return m << lane;
  endfunction

  // bit mask of an element's value in the low bits
  function automatic logic [63:0] elem_mask(ew_t w);
    case (w)
      EW8:     return 64'h0000_0000_0000_00FF;
      EW16:    return 64'h0000_0000_0000_FFFF;
      EW32:    return 64'h0000_0000_FFFF_FFFF;
      default: return 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/ewr_addr.sv
module ewr_addr
  import ewr_pkg::*;
#(
  parameter int NREGS = 32,
  parameter int IDX_W = 8
) (
  input  logic                     mode,
  input  ew_t                      wsel,
  input  logic [$clog2(NREGS)-1:0] base,
  input  logic [IDX_W-1:0]         idx,
  output logic [$clog2(NREGS)-1:0] reg_sel,
  output logic [2:0]               lane,
  output logic                     err
);
  localparam int REG_W = $clog2(NREGS);
  localparam int OFF_W = IDX_W + 3;

  logic [OFF_W-1:0] ub_off;
  logic [OFF_W-1:0] off;
  logic [4:0]       cnt;
  logic [3:0]       slot;
  logic [3:0]       vb_off;

  always_comb begin
    ub_off  = OFF_W'(idx) << wsel;
    cnt     = vec_count(wsel);
    err     = mode && (32'(idx) >= 32'(cnt));
    slot    = 4'(cnt - 5'd1 - 5'(idx));
    vb_off  = 4'(slot << wsel);
    off     = mode ? OFF_W'(vb_off) : ub_off;
    reg_sel = REG_W'(OFF_W'(base) + (off >> 3));
    lane    = off[2:0];
  end
endmodule

// File: rtl/ewr_lane.sv
module ewr_lane
  import ewr_pkg::*;
(
  input  ew_t         wsel,
  input  logic [2:0]  lane,
  input  logic [63:0] wr_data,
  input  logic [63:0] rd_word,
  output logic [7:0]  be,
  output logic [63:0] wr_word,
  output logic [63:0] rd_elem
);
  always_comb begin
    be      = lane_mask(wsel, lane);
    wr_word = wr_data << {lane, 3'b000};
    rd_elem = (rd_word >> {lane, 3'b000}) & elem_mask(wsel);
  end
endmodule

// File: rtl/ewr_store.sv
module ewr_store #(
  parameter int NREGS = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [$clog2(NREGS)-1:0] sel,
  input  logic [7:0]               be,
  input  logic [63:0]              wr_word,
  output logic [63:0]              rd_word,
  output logic [NREGS-1:0]         touched
);
  localparam int LANES = 8;

  logic [7:0] bytes_q [NREGS][LANES];

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    assign touched[r] = we && (sel == r[$clog2(NREGS)-1:0]) && (|be);
    for (genvar b = 0; b < LANES; b++) begin : g_byte
      always_ff @(posedge clk) begin
        if (rst)
          bytes_q[r][b] <= 8'h00;
        else if (touched[r] && be[b])
          bytes_q[r][b] <= wr_word[b*8 +: 8];
      end
    end
  end

  always_comb begin
    for (int b = 0; b < LANES; b++)
      rd_word[b*8 +: 8] = bytes_q[sel][b];
  end
endmodule

// File: rtl/ewr_regfile.sv
module ewr_regfile
  import ewr_pkg::*;
#(
  parameter int NREGS = 32,
  parameter int IDX_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     mode,
  input  logic [1:0]               wsel,
  input  logic [$clog2(NREGS)-1:0] base,
  input  logic [IDX_W-1:0]         idx,
  input  logic                     wr_en,
  input  logic [63:0]              wr_data,
  output logic [63:0]              rd_data,
  output logic                     err
);
  localparam int REG_W = $clog2(NREGS);

  ew_t              w;
  logic [REG_W-1:0] reg_sel;
  logic [2:0]       lane;
  logic [7:0]       be;
  logic [63:0]      wr_word;
  logic [63:0]      rd_word;
  logic [63:0]      rd_elem;
  logic             we_eff;
  logic [NREGS-1:0] touched;

  assign w = ew_t'(wsel);

  ewr_addr #(.NREGS(NREGS), .IDX_W(IDX_W)) u_addr (
    .mode(mode), .wsel(w), .base(base), .idx(idx),
    .reg_sel(reg_sel), .lane(lane), .err(err)
  );

  ewr_lane u_lane (
    .wsel(w), .lane(lane), .wr_data(wr_data), .rd_word(rd_word),
    .be(be), .wr_word(wr_word), .rd_elem(rd_elem)
  );

  assign we_eff = wr_en && !err;

  ewr_store #(.NREGS(NREGS)) u_store (
    .clk(clk), .rst(rst), .we(we_eff), .sel(reg_sel), .be(be),
    .wr_word(wr_word), .rd_word(rd_word), .touched(touched)
  );

  assign rd_data = err ? 64'd0 : rd_elem;
endmodule

// File: rtl/ewr_chk.sv
module ewr_chk
  import ewr_pkg::*;
#(
  parameter int NREGS = 32,
  parameter int IDX_W = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     mode,
  input logic [1:0]               wsel,
  input logic [$clog2(NREGS)-1:0] base,
  input logic [IDX_W-1:0]         idx,
  input logic                     wr_en,
  input logic [63:0]              wr_data,
  input logic [63:0]              rd_data,
  input logic                     err,
  input logic [7:0]               be,
  input logic [NREGS-1:0]         touched
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> rd_data == 64'd0);

  // R2
  zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (wsel != 2'd3) |-> ((rd_data >> (8 << wsel)) == 64'd0));

  // R3
  linear_no_err_chk: assert property (@(posedge clk) disable iff (rst)
    !mode |-> !err);

  // R6
  err_blocks_write_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> (touched == '0));

  // R7
  be_width_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !err) |-> ($countones(be) == (1 << wsel)));

  // R7
  one_reg_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(touched));

  // R8
  readback_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !err) |=>
      (!($stable(mode) && $stable(wsel) && $stable(base) && $stable(idx)) ||
       rd_data == $past(wr_data & elem_mask(ew_t'(wsel)))));
endmodule

bind ewr_regfile ewr_chk #(.NREGS(NREGS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .wsel(wsel), .base(base), .idx(idx),
  .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .err(err),
  .be(be), .touched(touched)
);

// File: tb/tb_ewr_regfile.sv
module tb_ewr_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode = 1'b0;
  logic [1:0]  wsel = 2'd3;
  logic [4:0]  base = 5'd0;
  logic [7:0]  idx = 8'd0;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = 64'd0;
  logic [63:0] rd_data;
  logic        err;

  ewr_regfile dut (
    .clk(clk), .rst(rst), .mode(mode), .wsel(wsel), .base(base), .idx(idx),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .err(err)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] mb [256];
  logic [63:0] q_rd [$];
  logic        q_err [$];
  string       q_tag [$];
  event        mon_ev;

  // flat byte-array model of the storage
  task automatic locate(input bit m, input int w, input int b, input int i,
                        output int ba, output bit e, output int nb);
    int n;
    nb = 1 << w;
    n  = 16 / nb;
    e  = 1'b0;
    if (!m) ba = (b * 8 + i * nb) % 256;
    else begin
      e  = (i >= n);
      ba = (b * 8 + (n - 1 - i) * nb) % 256;
    end
  endtask

  task automatic access(input bit m, input int w, input int b, input int i,
                        input bit we, input logic [63:0] d, input string tag);
    int ba, nb;
    bit e;
    logic [63:0] v;
    @(negedge clk);
    mode = m; wsel = 2'(w); base = 5'(b); idx = 8'(i);
    wr_en = we; wr_data = d;
    locate(m, w, b, i, ba, e, nb);
    v = 64'd0;
    if (!e)
      for (int k = 0; k < nb; k++) v[8*k +: 8] = mb[(ba + k) % 256];
    #2;
    q_rd.push_back(v); q_err.push_back(e); q_tag.push_back(tag);
    -> mon_ev;
    if (we && !e)
      for (int k = 0; k < nb; k++) mb[(ba + k) % 256] = d[8*k +: 8];
  endtask

  task automatic rd(input bit m, input int w, input int b, input int i, input string tag);
    access(m, w, b, i, 1'b0, 64'd0, tag);
  endtask

  task automatic wr(input bit m, input int w, input int b, input int i,
                    input logic [63:0] d, input string tag);
    access(m, w, b, i, 1'b1, d, tag);
  endtask

  // monitor: compares each design result with the queued expectation
  initial begin
    forever begin
      @(mon_ev);
      #1;
      while (q_rd.size() > 0) begin
        logic [63:0] er;
        logic ee;
        string t;
        er = q_rd.pop_front(); ee = q_err.pop_front(); t = q_tag.pop_front();
        checks++;
        if (rd_data !== er || err !== ee) begin
          fails++;
          $display("FAIL %s: rd_data=%h err=%b expected rd_data=%h err=%b",
                   t, rd_data, err, er, ee);
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 256; a++) mb[a] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    rd(0, 3, 0, 0, "R1 reg0 after reset");
    rd(0, 3, 17, 0, "R1 reg17 after reset");
    rd(0, 3, 31, 0, "R1 reg31 after reset");

    wr(0, 3, 3, 0, 64'h1122_3344_5566_7788, "R8 write 64b");
    rd(0, 3, 3, 0, "R8 readback 64b");

    wr(0, 0, 3, 2, 64'hFFFF_FFFF_FFFF_FFAB, "R7 byte write");
    rd(0, 3, 3, 0, "R7 only byte 2 changed");
    rd(0, 1, 3, 1, "R2 16b read zero-extended");
    rd(0, 0, 3, 7, "R2 8b read top byte");

    wr(0, 0, 3, 9, 64'h5C, "R3 overflow byte write");
    rd(0, 3, 4, 0, "R3 overflow lands in reg4");
    wr(0, 1, 3, 5, 64'hBEEF, "R3 16b overflow write");
    rd(0, 3, 4, 0, "R3 reg4 lanes 2-3");

    wr(0, 3, 31, 2, 64'h0123_4567_89AB_CDEF, "R4 wrap write");
    rd(0, 3, 1, 0, "R4 wrapped into reg1");
    wr(0, 2, 30, 5, 64'hDEAD_BEEF, "R4 32b wrap write");
    rd(0, 3, 0, 0, "R4 wrapped into reg0 upper");

    wr(1, 2, 6, 0, 64'hCAFE_F00D, "R5 vec 32b elem0");
    rd(0, 3, 7, 0, "R5 elem0 at top of high half");
    wr(1, 0, 6, 15, 64'h77, "R5 vec 8b elem15");
    rd(0, 3, 6, 0, "R5 elem15 at byte0");
    rd(1, 2, 6, 0, "R5 vec read elem0");
    wr(1, 3, 31, 1, 64'hA5A5_0000_5A5A_FFFF, "R5 vec spans 31 and 0");
    rd(0, 3, 31, 0, "R5 elem1 in reg31");
    rd(1, 3, 31, 0, "R5 elem0 in reg0");

    wr(1, 2, 6, 4, 64'h1111_2222, "R6 out-of-range 32b");
    rd(0, 3, 7, 0, "R6 reg7 unchanged");
    rd(0, 3, 8, 0, "R6 reg8 unchanged");
    wr(1, 0, 6, 16, 64'h99, "R6 out-of-range 8b");
    rd(0, 3, 6, 0, "R6 reg6 unchanged");
    rd(1, 1, 6, 7, "R6 last legal index");
    rd(1, 3, 6, 2, "R6 64b index 2 errs");

    for (int i = 0; i < 40; i++)
      wr(0, 0, 10, i, 64'(8'(i * 7 + 3)), "R3 byte stream");
    for (int r = 10; r < 16; r++)
      rd(0, 3, r, 0, "R3 stream readback");

    @(negedge clk);
    wr_en = 1'b0;
    #5;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule